// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block generates and checks even parity for a 32-bit multiplexed address/data bus and its 4-bit command/byte-enable bus. Each cycle the bus logic tells it which phase is completing: address, write data or read data. It also says whether the local agent is the initiator (master) or the responder (target). From these it works out which side owns the parity pin for that phase.

When the local agent owns the data, the block drives the parity pin one clock after the data it covers, with a matching output enable. When the local agent receives the data, the block compares the parity pin sampled one clock later against its own computation. A data-phase mismatch pulls the active-low parity-error pin low two clocks after the data was received. That pin is then driven high for one clock and released. An address-phase mismatch seen as target is reported on a separate open-drain system-error line, which the block pulls low for one clock.

A single enable input gates all error reporting. The bus pins are split into value and enable outputs so that pad logic outside the block builds the tri-states. The sequencing of the bus itself is handled elsewhere. There is no streaming interface here: every pin is a plain per-cycle control or status signal, so there is no back-pressure.

Top module: `bus_parity_unit`

## Requirements
- R1: `par_o` in cycle N+1 equals the XOR of all 36 bits of `ad_i` and `cbe_i` in cycle N, so that those bits together with the parity bit have an even number of ones.
- R2: `par_oe_o` is high in cycle N+1 exactly when cycle N was a locally driven phase: an address phase or a write data phase with `is_master_i`=1, or a read data phase with `is_master_i`=0. Otherwise it is low.
- R3: A received data phase is a write data phase with `is_master_i`=0 or a read data phase with `is_master_i`=1. If the data phase is in cycle N and `par_i` in cycle N+1 differs from the even parity of cycle N's bus, then `perr_oe_o`=1 and `perr_o`=0 in cycle N+2.
- R4: In the cycle after a low drive of the parity-error pin that has no new error, `perr_oe_o`=1 and `perr_o`=1. In the cycle after that (again with no new error), `perr_oe_o`=0.
- R5: Erroring data phases on consecutive cycles keep `perr_o` driven low without a gap.
- R6: An address phase with `is_master_i`=0 in cycle N whose parity mismatches `par_i` in cycle N+1 raises `serr_oe_o` for exactly cycle N+2.
- R7: When `chk_en_i` is 0 in the cycle of the address or data phase, that phase reports no error on either error output.
- R8: An address phase with `is_master_i`=1 is never checked, so it never raises `serr_oe_o`.
- R9: While `rst_n` is low, `par_oe_o`, `perr_oe_o` and `serr_oe_o` are 0 and `perr_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data bus value this cycle |
| cbe_i | input | 4 | Command/byte-enable bus value this cycle |
| addr_ph_i | input | 1 | Address phase completes this cycle |
| wdata_ph_i | input | 1 | Write data phase completes this cycle |
| rdata_ph_i | input | 1 | Read data phase completes this cycle |
| is_master_i | input | 1 | Local agent is the initiator of the current transaction |
| chk_en_i | input | 1 | Parity error reporting enable |
| par_i | input | 1 | Parity pin as sampled from the bus |
| par_o | output | 1 | Parity value to drive |
| par_oe_o | output | 1 | Parity pin output enable |
| perr_o | output | 1 | Active-low data parity error value |
| perr_oe_o | output | 1 | Data parity error pin output enable |
| serr_oe_o | output | 1 | Pull system-error line low (open drain) |

## Verification
If the expected-parity or receive-flag register held a wrong value, the mismatch would show as a spurious or missing parity-error drive exactly two cycles after the affected data phase. A stuck release flag would show in the cycle after the error. A wrong drive-ownership register would flip `par_oe_o` one cycle after the phase. The reference model is compared against every output on every clock. Any fault in these registers therefore surfaces within two cycles of the first phase that exercises it. The stimulus mixes roles, phase kinds, injected parity faults and the check enable.

// File: rtl/bus_parity_pkg.sv
package bus_parity_pkg;
  localparam int unsigned AD_W  = 32;
  localparam int unsigned CBE_W = 4;

  typedef struct packed {
    logic addr;
    logic wdata;
    logic rdata;
  } phase_t;
endpackage

// File: rtl/bus_parity_tree.sv
module bus_parity_tree #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4,
  parameter int unsigned LANE  = 8
) (
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  output logic             par_o
);
  localparam int unsigned NLANE = (AD_W + LANE - 1) / LANE;
  localparam int unsigned PAD_W = NLANE * LANE;

  logic [PAD_W-1:0] padded;
  logic [NLANE-1:0] lane_par;

  assign padded = {{(PAD_W-AD_W){1'b0}}, ad_i};

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_par[g] = ^padded[g*LANE +: LANE];
  end

  assign par_o = (^lane_par) ^ (^cbe_i);
endmodule

// File: rtl/bus_parity_drive.sv
module bus_parity_drive
  import bus_parity_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t ph_i,
  input  logic   is_master_i,
  input  logic   calc_par_i,
  output logic   par_o,
  output logic   par_oe_o
);
  logic own_now;

  assign own_now = (is_master_i & (ph_i.addr | ph_i.wdata)) |
                   (~is_master_i & ph_i.rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_o    <= calc_par_i;
      par_oe_o <= own_now;
    end
  end

  // R2: a locally owned phase enables the parity pin on the next clock
  assert_oe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master_i && ph_i.addr) |=> par_oe_o);
  assert_no_oe_on_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master_i && ph_i.wdata && !ph_i.addr && !ph_i.rdata) |=> !par_oe_o);
endmodule

// File: rtl/bus_parity_check.sv
module bus_parity_check
  import bus_parity_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t ph_i,
  input  logic   is_master_i,
  input  logic   chk_en_i,
  input  logic   calc_par_i,
  input  logic   par_i,
  output logic   perr_o,
  output logic   perr_oe_o,
  output logic   serr_oe_o
);
  logic rx_data_q, rx_addr_q, exp_q;
  logic perr_act_q, perr_rel_q, serr_q;
  logic mism, err_data, err_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data_q <= 1'b0;
      rx_addr_q <= 1'b0;
      exp_q     <= 1'b0;
    end else begin
      rx_data_q <= chk_en_i & ((~is_master_i & ph_i.wdata) | (is_master_i & ph_i.rdata));
      rx_addr_q <= chk_en_i & ~is_master_i & ph_i.addr;
      exp_q     <= calc_par_i;
    end
  end

  assign mism     = par_i ^ exp_q;
  assign err_data = rx_data_q & mism;
  assign err_addr = rx_addr_q & mism;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_act_q <= 1'b0;
      perr_rel_q <= 1'b0;
      serr_q     <= 1'b0;
    end else begin
      perr_act_q <= err_data;
      perr_rel_q <= perr_act_q & ~err_data;
      serr_q     <= err_addr;
    end
  end

  assign perr_o    = ~perr_act_q;
  assign perr_oe_o = perr_act_q | perr_rel_q;
  assign serr_oe_o = serr_q;

  // R4: after a low drive the pin is either low again or driven high
  assert_low_then_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe_o && !perr_o) |=> perr_oe_o);
  // R4: the high drive lasts one clock only
  assert_high_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe_o && perr_o) |=> (!perr_oe_o || !perr_o));
  // R7: an error drive traces back to an enabled data phase two clocks earlier
  assert_suppress_R7: assert property (@(posedge clk) disable iff (!rst_n)
    perr_act_q |-> $past(chk_en_i, 2));
  // R6 and R8: system error only from a target-side address phase
  assert_serr_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe_o |-> ($past(ph_i.addr, 2) && !$past(is_master_i, 2)));
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
  import bus_parity_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             addr_ph_i,
  input  logic             wdata_ph_i,
  input  logic             rdata_ph_i,
  input  logic             is_master_i,
  input  logic             chk_en_i,
  input  logic             par_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_o,
  output logic             perr_oe_o,
  output logic             serr_oe_o
);
  phase_t ph;
  logic   calc_par;

  assign ph = '{addr: addr_ph_i, wdata: wdata_ph_i, rdata: rdata_ph_i};

  bus_parity_tree #(.AD_W(AD_W), .CBE_W(CBE_W), .LANE(8)) u_tree (
    .ad_i  (ad_i),
    .cbe_i (cbe_i),
    .par_o (calc_par)
  );

  bus_parity_drive u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .ph_i        (ph),
    .is_master_i (is_master_i),
    .calc_par_i  (calc_par),
    .par_o       (par_o),
    .par_oe_o    (par_oe_o)
  );

  bus_parity_check u_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .ph_i        (ph),
    .is_master_i (is_master_i),
    .chk_en_i    (chk_en_i),
    .calc_par_i  (calc_par),
    .par_i       (par_i),
    .perr_o      (perr_o),
    .perr_oe_o   (perr_oe_o),
    .serr_oe_o   (serr_oe_o)
  );

  // R9: reset leaves every pin released
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> (!rst_n -> (!par_oe_o && !perr_oe_o && !serr_oe_o)));
endmodule

// File: tb/bus_parity_unit_tb.sv
module bus_parity_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic        aph = 0, wph = 0, rph = 0, mst = 0, chk = 1, pin = 0;
  logic        par_o, par_oe, perr, perr_oe, serr_oe;

  int vectors = 0;
  int errors  = 0;

  logic m_par, m_paroe, m_act, m_rel, m_serr, m_rxd, m_rxa, m_exp;
  logic [35:0] prev_bus = '0;

  always #2 clk = ~clk;

  bus_parity_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_i(cbe),
    .addr_ph_i(aph), .wdata_ph_i(wph), .rdata_ph_i(rph),
    .is_master_i(mst), .chk_en_i(chk), .par_i(pin),
    .par_o(par_o), .par_oe_o(par_oe), .perr_o(perr),
    .perr_oe_o(perr_oe), .serr_oe_o(serr_oe)
  );

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    logic bp, ed, ea;
    if (!rst_n) begin
      m_par = 0; m_paroe = 0; m_act = 0; m_rel = 0; m_serr = 0;
      m_rxd = 0; m_rxa = 0; m_exp = 0;
    end else begin
      ed = m_rxd && (pin != m_exp);
      ea = m_rxa && (pin != m_exp);
      m_rel  = m_act && !ed;
      m_act  = ed;
      m_serr = ea;
      bp = 1'b0;
      for (int i = 0; i < 32; i++) bp = bp ^ ad[i];
      for (int i = 0; i < 4; i++)  bp = bp ^ cbe[i];
      m_par   = bp;
      m_exp   = bp;
      m_paroe = (mst && (aph || wph)) || (!mst && rph);
      m_rxd   = chk && ((!mst && wph) || (mst && rph));
      m_rxa   = chk && !mst && aph;
    end
  end

  task automatic cmp(input logic act, input logic exp, input string req);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // compare one time unit after each rising edge
  always @(posedge clk) begin
    #1;
    cmp(par_oe, m_paroe, "R2 par_oe");
    cmp(par_o, m_par, "R1 par value");
    cmp(perr_oe, m_act || m_rel, "R3/R4 perr_oe");
    if (m_act || m_rel) cmp(perr, !m_act, "R3/R5 perr value");
    cmp(serr_oe, m_serr, "R6/R8 serr_oe");
    if (!rst_n) cmp(perr, 1'b1, "R9 reset perr");
  end

  // drive one bus cycle at the falling edge; inj flips the parity of the previous cycle
  task automatic step(input logic a, input logic w, input logic r, input logic m,
                      input logic c, input logic inj);
    @(negedge clk);
    pin = (^prev_bus) ^ inj;
    ad  = $urandom; cbe = 4'($urandom);
    aph = a; wph = w; rph = r; mst = m; chk = c;
    prev_bus = {cbe, ad};
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3/R4: single data error as target on a write
    step(0,1,0,0,1,0); step(0,0,0,0,1,1); step(0,0,0,0,1,0);
    step(0,0,0,0,1,0); step(0,0,0,0,1,0);
    // R5: back-to-back read errors as master
    step(0,0,1,1,1,0); step(0,0,1,1,1,1); step(0,0,1,1,1,1);
    step(0,0,0,1,1,1); step(0,0,0,1,1,0); step(0,0,0,1,1,0);
    // R7: enable low suppresses a faulty phase
    step(0,1,0,0,0,0); step(0,0,0,0,1,1); step(0,0,0,0,1,0); step(0,0,0,0,1,0);
    // R6: target address error; R8: master address never checked
    step(1,0,0,0,1,0); step(0,0,0,0,1,1); step(1,0,0,1,1,0);
    step(0,0,0,1,1,1); step(0,0,0,1,1,0); step(0,0,0,1,1,0);
    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      int sel;
      sel = $urandom_range(0, 3);
      step(sel == 1, sel == 2, sel == 3, 1'($urandom), ($urandom_range(0, 7) != 0),
           ($urandom_range(0, 3) == 0));
    end
    // R9: reset mid-stream
    step(1,0,0,1,1,0);
    rst_n = 0;
    repeat (3) step(0,0,0,0,1,0);
    rst_n = 1;
    repeat (4) step(0,0,0,0,1,0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule